// File: doc/BRIEF.md
# Banked Warp Scratchpad

This block is an on-chip scratchpad that serves one warp-wide access request at a time. A request carries 32 lanes. Each lane has an active bit, a word address, a read/write flag and a write word. The storage is split into 32 banks of 32-bit words. The low bits of a word address choose the bank and the high bits choose the row inside that bank. Each bank can serve one row per clock. Lanes whose addresses fall in different banks are therefore served in the same cycle.

When several lanes point at different rows of one bank, the block replays over extra cycles. In each cycle, every bank serves the address of its lowest-numbered pending lane. Every pending lane that uses that same address is served with it. Lanes reading one identical word share a single bank access, and the word is broadcast to all of them. When the request is finished, the block raises a one-cycle done pulse. It then presents the per-lane read words and the number of service cycles used. Both stay unchanged until the next request is accepted.

A new request is taken on any clock edge where `req_valid` is high and `req_ready` is high.

Top module: `banked_scratchpad`

## Requirements
- R1: Word address A is stored in bank A mod 32, at row A / 32. Each of the 1024 words holds its own value.
- R2: A request whose active lanes all use different banks completes in one service cycle (`rsp_cycles` = 1).
- R3: `rsp_cycles` equals the largest number of distinct addresses that the active lanes map to any single bank, with a minimum of 1 (a request with no active lane takes 1). `rsp_done` rises exactly that many clock edges after the accepting edge.
- R4: Any number of lanes reading one identical word all receive that word, and they add no service cycle.
- R5: When several active lanes write the same word in one request, the word ends up holding the data of the highest-numbered of those lanes.
- R6: A read returns the word as it was before the current request. This holds even when another lane of the same request writes that word.
- R7: The read data of an inactive lane, and of a write lane, is zero when `rsp_done` is high.
- R8: `rsp_rdata` and `rsp_cycles` do not change from the done pulse until the next request is accepted.
- R9: `req_ready` is low from the edge after acceptance until the done pulse. `rsp_done` is high for exactly one cycle per request.
- R10: After reset, `req_ready` is 1, `rsp_done` is 0, `rsp_cycles` is 0 and all read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Block idle; a valid request is taken at the next edge |
| req_active | input | 32 | Per-lane active bit, bit l for lane l |
| req_write | input | 32 | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | 320 | Per-lane 10-bit word address, lane l at bits [10l+9:10l] |
| req_wdata | input | 1024 | Per-lane write word, lane l at bits [32l+31:32l] |
| rsp_done | output | 1 | One-cycle pulse when the request is complete |
| rsp_cycles | output | 6 | Number of service cycles the last request used |
| rsp_rdata | output | 1024 | Per-lane read word, lane l at bits [32l+31:32l] |

## Verification
The request is driven on a falling edge and taken at the next rising edge. The done pulse and the results then appear exactly K rising edges later, where K is the conflict depth that the bench computes from the lane addresses. The bench counts rising edges from acceptance and samples each falling edge. It compares the edge count with K, checks that ready stays low on every sample before done, and reads the data and cycle count on the falling edge where done is first seen. Hold behaviour is checked again several idle cycles later, against the values captured at done.

// File: rtl/scratch_pkg.sv
// Package: shared types for the banked scratchpad.
// Assumes: nothing beyond a two-state controller.
package scratch_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } serve_state_t;

endpackage

// File: rtl/bank_arbiter.sv
// Module: bank_arbiter
// Picks, for one bank, the address of the lowest-numbered pending lane
// that maps to this bank. Every pending lane at that address is marked served.
// Merges the writes to that address so that the highest served writer wins.
// Assumes: the bank index is the low BANK_W bits of the word address.
module bank_arbiter #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int BANK_W  = 5,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]        pending,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES*DATA_W-1:0] lane_wdata,
    output logic [LANES-1:0]        served,
    output logic [ROW_W-1:0]        row,
    output logic                    wr_en,
    output logic [DATA_W-1:0]       wr_data
);

    logic [LANES-1:0]  hit;
    logic              found;
    logic [ADDR_W-1:0] lead_addr;

    // Select the lead address and the lanes that share it.
    always_comb begin
        found     = 1'b0;
        lead_addr = '0;
        for (int l = 0; l < LANES; l++) begin
            hit[l] = pending[l] &&
                     (lane_addr[l*ADDR_W +: BANK_W] == BANK_W'(BANK_ID));
            if (hit[l] && !found) begin
                found     = 1'b1;
                lead_addr = lane_addr[l*ADDR_W +: ADDR_W];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            served[l] = hit[l] && (lane_addr[l*ADDR_W +: ADDR_W] == lead_addr);
        end
        row = lead_addr[ADDR_W-1:BANK_W];
    end

    // Merge writes: a later (higher) lane overrides an earlier one.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        for (int l = 0; l < LANES; l++) begin
            if (served[l] && lane_wr[l]) begin
                wr_en   = 1'b1;
                wr_data = lane_wdata[l*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/bank_store.sv
// Module: bank_store
// Storage for one bank: ROWS words, with one read or write row per clock.
// The read is combinational from the row, so a write at an edge is seen
// only after that edge.
// Assumes: the storage is not reset; contents are undefined until written.
module bank_store #(
    parameter int ROW_W  = 5,
    parameter int DATA_W = 32,
    localparam int ROWS  = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [ROWS];

    // Write the addressed row when enabled.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[row] <= wr_data;
        end
    end

    assign rd_data = mem[row];

endmodule

// File: rtl/banked_scratchpad.sv
// Module: banked_scratchpad (top)
// Serves one warp request across BANKS interleaved banks. Bank conflicts
// are resolved by replaying the request. Reads of the same word are
// broadcast. Results are held after the done pulse.
// Assumes: one request in flight; the inputs are captured at acceptance.
module banked_scratchpad #(
    parameter int LANES  = 32,
    parameter int BANKS  = 32,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [LANES-1:0]           req_active,
    input  logic [LANES-1:0]           req_write,
    input  logic [LANES*ADDR_W-1:0]    req_addr,
    input  logic [LANES*DATA_W-1:0]    req_wdata,
    output logic                       rsp_done,
    output logic [$clog2(LANES+1)-1:0] rsp_cycles,
    output logic [LANES*DATA_W-1:0]    rsp_rdata
);
    import scratch_pkg::*;

    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int CNT_W  = $clog2(LANES + 1);

    serve_state_t            state_q;
    logic [LANES-1:0]        act_q;
    logic [LANES-1:0]        wr_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES*DATA_W-1:0] wdata_q;
    logic [LANES*DATA_W-1:0] rdata_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    done_q;

    logic [LANES-1:0]  served_bank [BANKS];
    logic [DATA_W-1:0] bank_rd     [BANKS];
    logic [LANES-1:0]  served_all;
    logic [LANES-1:0]  pend_next;
    logic              accept;

    // One arbiter and one storage bank per bank index.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [ROW_W-1:0]  row;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;

        bank_arbiter #(
            .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .BANK_W(BANK_W), .BANK_ID(b)
        ) u_arb (
            .pending   (pend_q),
            .lane_wr   (wr_q),
            .lane_addr (addr_q),
            .lane_wdata(wdata_q),
            .served    (served_bank[b]),
            .row       (row),
            .wr_en     (wr_en),
            .wr_data   (wr_data)
        );

        bank_store #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_store (
            .clk    (clk),
            .wr_en  (wr_en),
            .row    (row),
            .wr_data(wr_data),
            .rd_data(bank_rd[b])
        );
    end

    // Collect the lanes served this cycle over all banks.
    always_comb begin
        served_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            served_all = served_all | served_bank[b];
        end
        pend_next = pend_q & ~served_all;
    end

    assign accept = req_valid && (state_q == ST_IDLE);

    // Controller: capture the request, replay until no lane is pending, hold the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
            wr_q    <= '0;
            pend_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_SERVE;
                act_q   <= req_active;
                wr_q    <= req_write;
                pend_q  <= req_active;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                rdata_q <= '0;
                cnt_q   <= '0;
            end else if (state_q == ST_SERVE) begin
                cnt_q  <= cnt_q + 1'b1;
                pend_q <= pend_next;
                for (int l = 0; l < LANES; l++) begin
                    if (served_all[l] && !wr_q[l]) begin
                        rdata_q[l*DATA_W +: DATA_W] <=
                            bank_rd[addr_q[l*ADDR_W +: BANK_W]];
                    end
                end
                if (pend_next == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_done   = done_q;
    assign rsp_cycles = cnt_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/banked_scratchpad_chk.sv
// Module: banked_scratchpad_chk
// Checks the timing of the handshake and the response on the top module.
// Attached to the top module through a bind.
// Assumes: lane_act and lane_wr are the request flags captured at acceptance.
module banked_scratchpad_chk #(
    parameter int LANES  = 32,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       rsp_done,
    input logic [$clog2(LANES+1)-1:0] rsp_cycles,
    input logic [LANES*DATA_W-1:0]    rsp_rdata,
    input logic [LANES-1:0]           lane_act,
    input logic [LANES-1:0]           lane_wr
);

    logic [LANES*DATA_W-1:0] quiet_mask;

    // Expand the per-lane quiet flag (inactive or write) into a data mask.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            quiet_mask[l*DATA_W +: DATA_W] =
                {DATA_W{!lane_act[l] || lane_wr[l]}};
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_done));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(rsp_rdata) && $stable(rsp_cycles)));

    // R3
    cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_cycles >= 1 && rsp_cycles <= LANES));

    // R7
    quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ((rsp_rdata & quiet_mask) == '0));

endmodule

bind banked_scratchpad banked_scratchpad_chk #(
    .LANES(LANES), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_cycles(rsp_cycles),
    .rsp_rdata (rsp_rdata),
    .lane_act  (act_q),
    .lane_wr   (wr_q)
);

// File: tb/banked_scratchpad_tb.sv
`timescale 1ns/1ps
module banked_scratchpad_tb;

    localparam int LANES  = 32;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int WORDS  = 1 << ADDR_W;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    req_valid;
    logic                    req_ready;
    logic [LANES-1:0]        req_active;
    logic [LANES-1:0]        req_write;
    logic [LANES*ADDR_W-1:0] req_addr;
    logic [LANES*DATA_W-1:0] req_wdata;
    logic                    rsp_done;
    logic [5:0]              rsp_cycles;
    logic [LANES*DATA_W-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] model [WORDS];
    logic              t_act [LANES];
    logic              t_wr  [LANES];
    logic [ADDR_W-1:0] t_addr[LANES];
    logic [DATA_W-1:0] t_data[LANES];

    always #2 clk = ~clk;

    banked_scratchpad u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_active(req_active),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_cycles(rsp_cycles),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
        end
    endtask

    // Largest count of distinct addresses in one bank, at least 1.
    function automatic int exp_cycles();
        int worst = 0;
        for (int b = 0; b < 32; b++) begin
            int n = 0;
            for (int l = 0; l < LANES; l++) begin
                bit dup = 0;
                if (!t_act[l] || t_addr[l][4:0] != b[4:0]) continue;
                for (int j = 0; j < l; j++)
                    if (t_act[j] && t_addr[j] == t_addr[l]) dup = 1;
                if (!dup) n++;
            end
            if (n > worst) worst = n;
        end
        return (worst == 0) ? 1 : worst;
    endfunction

    task automatic clear_req();
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 0; t_wr[l] = 0; t_addr[l] = '0; t_data[l] = '0;
        end
    endtask

    // Drive one request, wait for done, compare against the model, update the model.
    task automatic run_req(input string rq);
        int k;
        int n;
        logic [DATA_W-1:0] exp_rd [LANES];
        logic [LANES*DATA_W-1:0] held_rd;
        logic [5:0] held_cnt;
        k = exp_cycles();
        for (int l = 0; l < LANES; l++)
            exp_rd[l] = (t_act[l] && !t_wr[l]) ? model[t_addr[l]] : '0;
        @(negedge clk);
        for (int l = 0; l < LANES; l++) begin
            req_active[l] = t_act[l];
            req_write[l]  = t_wr[l];
            req_addr[l*ADDR_W +: ADDR_W]  = t_addr[l];
            req_wdata[l*DATA_W +: DATA_W] = t_data[l];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 100) begin
            check("R9", "ready low while busy", 64'(req_ready), 64'd0);
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        check("R3", "edges to done", 64'(n), 64'(k));
        check(rq, "cycle count", 64'(rsp_cycles), 64'(k));
        for (int l = 0; l < LANES; l++)
            check(rq, $sformatf("lane %0d read data", l),
                  64'(rsp_rdata[l*DATA_W +: DATA_W]), 64'(exp_rd[l]));
        held_rd  = rsp_rdata;
        held_cnt = rsp_cycles;
        for (int l = 0; l < LANES; l++)
            if (t_act[l] && t_wr[l]) model[t_addr[l]] = t_data[l];
        repeat (3) @(negedge clk);
        check("R8", "read data held", 64'(rsp_rdata == held_rd), 64'd1);
        check("R8", "count held", 64'(rsp_cycles), 64'(held_cnt));
        check("R9", "done pulse ended", 64'(rsp_done), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; req_valid = 1'b0;
        req_active = '0; req_write = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "ready", 64'(req_ready), 64'd1);
        check("R10", "done", 64'(rsp_done), 64'd0);
        check("R10", "cycles", 64'(rsp_cycles), 64'd0);
        check("R10", "rdata zero", 64'(rsp_rdata == '0), 64'd1);

        // R1 fill every word through conflict-free writes
        for (int r = 0; r < WORDS / LANES; r++) begin
            for (int l = 0; l < LANES; l++) begin
                t_act[l] = 1; t_wr[l] = 1;
                t_addr[l] = ADDR_W'(r * 32 + l);
                t_data[l] = 32'hA5000000 ^ (r * 32 + l) * 32'h9E3779B1;
            end
            run_req("R1");
        end
        // R2 unit stride reads over several rows
        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < LANES; l++) begin
                t_act[l] = 1; t_wr[l] = 0; t_addr[l] = ADDR_W'(r * 97 + l);
            end
            run_req("R2");
        end
        // R3 stride of two: two rows per even bank
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 1; t_wr[l] = 0; t_addr[l] = ADDR_W'(2 * l);
        end
        run_req("R3");
        // R4 broadcast of one word to all lanes
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 1; t_wr[l] = 0; t_addr[l] = ADDR_W'(77);
        end
        run_req("R4");
        // R3 worst case: all lanes in one bank at different rows
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 1; t_wr[l] = 0; t_addr[l] = ADDR_W'(l * 32 + 5);
        end
        run_req("R3");
        // R4 broadcast groups inside a conflicting bank
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 1; t_wr[l] = 0; t_addr[l] = (l % 2) ? ADDR_W'(35) : ADDR_W'(3);
        end
        run_req("R4");
        // R3 / R7 request with no active lane
        clear_req();
        run_req("R7");
        // R5 all lanes write one word, then read it back
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 1; t_wr[l] = 1; t_addr[l] = ADDR_W'(100);
            t_data[l] = 32'h1000 + l;
        end
        run_req("R5");
        clear_req();
        t_act[0] = 1; t_addr[0] = ADDR_W'(100);
        run_req("R5");
        check("R5", "highest writer stored", 64'(rsp_rdata[DATA_W-1:0]), 64'h101F);
        // R6 reads and writes of one word in the same request
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = 1; t_wr[l] = (l >= 16); t_addr[l] = ADDR_W'(200);
            t_data[l] = 32'hBEEF0000 + l;
        end
        run_req("R6");
        clear_req();
        t_act[3] = 1; t_addr[3] = ADDR_W'(200);
        run_req("R6");
        // R7 sparse active lanes with mixed writes
        for (int l = 0; l < LANES; l++) begin
            t_act[l] = (l % 3 != 0); t_wr[l] = (l % 4 == 1);
            t_addr[l] = ADDR_W'(l * 7); t_data[l] = 32'hC0DE0000 + l;
        end
        run_req("R7");
        // Random mix over narrow and wide address ranges
        for (int i = 0; i < 60; i++) begin
            for (int l = 0; l < LANES; l++) begin
                t_act[l]  = ($urandom % 4) != 0;
                t_wr[l]   = ($urandom % 4) == 0;
                t_addr[l] = (i % 2) ? ADDR_W'($urandom % 96) : ADDR_W'($urandom);
                t_data[l] = $urandom;
            end
            run_req("R3");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule